// File: doc/BRIEF.md
# Serial ADC Sample Capture Controller

This block sits on the host side of a three-wire serial converter. The wires are an active-low select, a data clock driven by the host, and a data line driven by the converter. A frame timer started by an enable input fires a trigger at a programmable period, and each trigger opens one read frame. The frame rate is the sample rate. Because the converter powers itself down after every conversion, low rates such as 1 kHz, 256 Hz or a few Hz only need a long period, and nothing has to be sent between frames.

In a frame the block pulls select low and toggles the data clock with a programmable half period. The data line carries a fixed sequence. It is undriven for the first five falling clock edges, and after the fifth falling edge the converter drives a low marker. The result then follows most significant bit first, one bit after each later falling edge. The block samples each bit on the rising edge that follows the falling edge that launched it. It checks the marker and shifts the result in. It then returns select high and presents the parallel word with a single-cycle strobe.

Top module: `sadc_capture`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `adc_csn_n` is 1, `adc_sclk` is 1 and `sample_valid` is 0.
- R2: With `enable` held high, a frame trigger fires every `frame_div`+1 clock cycles. The first trigger comes `frame_div`+1 cycles after `enable` is first sampled high. No trigger fires while `enable` is low, and lowering `enable` restarts the period count.
- R3: On the clock edge of a trigger that finds the block idle, `adc_csn_n` goes low with `adc_sclk` high. The clock then toggles every `sclk_div`+1 cycles, starting with a falling edge `sclk_div`+1 cycles after select falls.
- R4: A frame has exactly 5+DATA_W falling clock edges. On the edge where the clock rises after the last falling edge, `adc_csn_n` returns to 1 and `sample_valid` is 1 for that one cycle only. `sample_data` changes only on that cycle.
- R5: The data line is ignored at the rising edges that follow falling edges 1 to 4 of a frame.
- R6: The data line is sampled as the marker at the rising edge after falling edge 5. If the marker is 1, `marker_err` is 1 alongside that sample, and the data is still delivered. If the marker is 0, `marker_err` is 0. `marker_err` is valid while `sample_valid` is 1.
- R7: The data line is sampled at the rising edges after falling edges 6 to 5+DATA_W. The first of these bits lands in bit DATA_W-1 of `sample_data` and the last in bit 0.
- R8: A trigger that arrives while a frame is open pulses `overrun` for one cycle on the following cycle and leaves the open frame unchanged.
- R9: Whenever `adc_csn_n` is 1, `adc_sclk` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the periodic frame timer |
| frame_div | input | CNT_W | Frame period minus one, in clock cycles |
| sclk_div | input | DIV_W | Data clock half period minus one, in clock cycles |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_csn_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial data clock, high when idle |
| sample_data | output | DATA_W | Last captured result |
| sample_valid | output | 1 | One-cycle strobe for a new result |
| marker_err | output | 1 | Marker bit was high in the delivered sample |
| overrun | output | 1 | One-cycle pulse for a trigger dropped during a frame |

## Verification
A bit counter that is off by one would show on the data clock within one half period of the slip. The frame would then end one clock early or late, so select and the valid strobe would rise on the wrong cycle, and the result would arrive shifted by one bit position. If the frame timer or the busy state were wrong, the next select fall would come at the wrong cycle, or an overrun pulse would appear where none was due. A per-cycle reference comparison catches each of these on the first wrong cycle. A converter model that toggles the line during the dead edges shows whether those edges are sampled.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // falling edges before the converter drives its marker bit
    localparam int unsigned DEAD_FALLS = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } frame_state_e;

    // one-cycle events from the serial clock generator
    typedef struct packed {
        logic fall;
        logic rise;
    } sclk_evt_t;

    function automatic int unsigned total_falls(input int unsigned width);
        return DEAD_FALLS + width;
    endfunction

endpackage

// File: rtl/sadc_rate.sv
module sadc_rate #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_m1,
    output logic             trig
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == period_m1);
    assign trig = en && wrap && !rst;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sadc_sclk.sv
module sadc_sclk
    import sadc_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             sclk,
    output sclk_evt_t        evt
);
    logic [DIV_W-1:0] hcnt_q;
    logic             sclk_q;
    logic             toggle;

    assign toggle   = run && (hcnt_q == half_m1);
    assign evt.fall = toggle && sclk_q;
    assign evt.rise = toggle && !sclk_q;
    assign sclk     = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt_q <= '0;
            sclk_q <= 1'b1;
        end else if (toggle) begin
            hcnt_q <= '0;
            sclk_q <= !sclk_q;
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
    import sadc_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  sclk_evt_t         evt,
    input  logic              sdo,
    output logic              busy,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              merr,
    output logic              overrun
);
    localparam int unsigned LAST_FALL = total_falls(DATA_W);
    localparam int unsigned FC_W      = $clog2(LAST_FALL + 1);
    localparam logic [FC_W-1:0] MARK_IDX = FC_W'(DEAD_FALLS);
    localparam logic [FC_W-1:0] END_IDX  = FC_W'(LAST_FALL);

    frame_state_e      state_q;
    logic [FC_W-1:0]   falls_q;
    logic [DATA_W-1:0] shreg_q;
    logic              mark_q;
    logic [DATA_W-1:0] next_word;

    assign busy      = (state_q == ST_XFER);
    assign next_word = {shreg_q[DATA_W-2:0], sdo};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            falls_q <= '0;
            shreg_q <= '0;
            mark_q  <= 1'b0;
            data    <= '0;
            valid   <= 1'b0;
            merr    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            valid   <= 1'b0;
            overrun <= trig && busy;
            case (state_q)
                ST_IDLE: begin
                    if (trig) begin
                        state_q <= ST_XFER;
                        falls_q <= '0;
                    end
                end
                ST_XFER: begin
                    if (evt.fall) begin
                        falls_q <= falls_q + 1'b1;
                    end
                    if (evt.rise) begin
                        if (falls_q == MARK_IDX) begin
                            mark_q <= sdo;
                        end
                        if (falls_q > MARK_IDX) begin
                            shreg_q <= next_word;
                        end
                        if (falls_q == END_IDX) begin
                            data    <= next_word;
                            merr    <= mark_q;
                            valid   <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture
    import sadc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [CNT_W-1:0]  frame_div,
    input  logic [DIV_W-1:0]  sclk_div,
    input  logic              adc_sdo,
    output logic              adc_csn_n,
    output logic              adc_sclk,
    output logic [DATA_W-1:0] sample_data,
    output logic              sample_valid,
    output logic              marker_err,
    output logic              overrun
);
    logic      trig;
    logic      busy;
    sclk_evt_t evt;

    sadc_rate #(.CNT_W(CNT_W)) u_rate (
        .clk       (clk),
        .rst       (rst),
        .en        (enable),
        .period_m1 (frame_div),
        .trig      (trig)
    );

    sadc_sclk #(.DIV_W(DIV_W)) u_sclk (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .half_m1 (sclk_div),
        .sclk    (adc_sclk),
        .evt     (evt)
    );

    sadc_frame #(.DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .evt     (evt),
        .sdo     (adc_sdo),
        .busy    (busy),
        .data    (sample_data),
        .valid   (sample_valid),
        .merr    (marker_err),
        .overrun (overrun)
    );

    assign adc_csn_n = !busy;
endmodule

// File: rtl/sadc_capture_chk.sv
module sadc_capture_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_csn_n,
    input logic              adc_sclk,
    input logic [DATA_W-1:0] sample_data,
    input logic              sample_valid,
    input logic              overrun
);
    logic rst_seen_q = 1'b0;

    always @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q) begin
            // R1
            reset_idle_chk: assert (adc_csn_n && adc_sclk && !sample_valid);
        end
    end

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R4
    csn_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_csn_n) |-> sample_valid);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sample_data) |-> sample_valid);

    // R9
    idle_clock_high_chk: assert property (@(posedge clk) disable iff (rst)
        adc_csn_n |-> adc_sclk);

    // R8
    overrun_busy_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(!adc_csn_n));
endmodule

bind sadc_capture sadc_capture_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .adc_csn_n    (adc_csn_n),
    .adc_sclk     (adc_sclk),
    .sample_data  (sample_data),
    .sample_valid (sample_valid),
    .overrun      (overrun)
);

// File: tb/sadc_capture_bench.sv
`timescale 1ns/1ps
module sadc_capture_bench;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic [31:0]   frame_div = 32'd60;
    logic [15:0]   sclk_div = 16'd0;
    logic          adc_sdo = 1'b1;
    logic          adc_csn_n, adc_sclk, sample_valid, marker_err, overrun;
    logic [W-1:0]  sample_data;

    sadc_capture u_sadc_capture (
        .clk(clk), .rst(rst), .enable(enable), .frame_div(frame_div),
        .sclk_div(sclk_div), .adc_sdo(adc_sdo), .adc_csn_n(adc_csn_n),
        .adc_sclk(adc_sclk), .sample_data(sample_data),
        .sample_valid(sample_valid), .marker_err(marker_err), .overrun(overrun)
    );

    always #2.5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    int n_valid = 0, n_err = 0, n_ovr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h",
                     req, what, cyc, act, exp);
        end
    endtask

    // converter model: dead edges carry toggling garbage
    logic [W-1:0] seed = 16'hA5C3;
    logic [W-1:0] cur_word = '0;
    bit           cur_mark = 0, inject_mark = 0, csn_seen = 0;
    int           adc_falls = 0;

    always @(negedge adc_sclk, negedge adc_csn_n, posedge adc_csn_n) begin
        if (adc_csn_n !== 1'b0) begin
            adc_sdo  = 1'b1;
            csn_seen = 0;
        end else if (!csn_seen) begin
            csn_seen  = 1;
            seed      = seed * 16'd25173 + 16'd13849;
            cur_word  = seed;
            cur_mark  = inject_mark;
            adc_falls = 0;
            adc_sdo   = 1'b1;
        end else begin
            adc_falls++;
            if (adc_falls < 5)            adc_sdo = ~adc_sdo;
            else if (adc_falls == 5)      adc_sdo = cur_mark;
            else if (adc_falls <= 5 + W)  adc_sdo = cur_word[W-1-(adc_falls-6)];
            else                          adc_sdo = 1'b1;
        end
    end

    // behavioural reference, advanced on every rising clock edge
    int  rcnt = 0, age = 0, h;
    bit  busy = 0, trig;
    bit  e_csn = 1, e_sclk = 1, e_valid = 0, e_ovr = 0, e_err = 0;
    logic [W-1:0] e_data = '0;

    always @(posedge clk) begin
        cyc++;
        e_valid = 0;
        e_ovr   = 0;
        if (rst) begin
            rcnt = 0; busy = 0; age = 0; e_csn = 1; e_sclk = 1;
        end else begin
            h    = int'(sclk_div) + 1;
            trig = enable && (rcnt == int'(frame_div));
            if (!enable || trig) rcnt = 0; else rcnt++;
            if (busy) begin
                age++;
                if (trig) e_ovr = 1;
                if (age == 2 * (5 + W) * h) begin
                    busy = 0; e_valid = 1; e_data = cur_word; e_err = cur_mark;
                end
            end else if (trig) begin
                busy = 1; age = 0;
            end
            e_csn  = !busy;
            e_sclk = busy ? ((age / h) % 2 == 0) : 1'b1;
        end
    end

    always @(negedge clk) begin
        if (cyc >= 1) begin
            if (rst) begin
                chk(adc_csn_n === 1'b1, "R1", "select in reset", 32'(adc_csn_n), 1);
                chk(adc_sclk === 1'b1, "R1", "clock in reset", 32'(adc_sclk), 1);
                chk(sample_valid === 1'b0, "R1", "valid in reset", 32'(sample_valid), 0);
            end else begin
                chk(adc_csn_n === e_csn, "R2 R3", "select", 32'(adc_csn_n), 32'(e_csn));
                chk(adc_sclk === e_sclk, "R3 R9", "data clock", 32'(adc_sclk), 32'(e_sclk));
                chk(sample_valid === e_valid, "R4", "valid strobe", 32'(sample_valid), 32'(e_valid));
                chk(overrun === e_ovr, "R8", "overrun", 32'(overrun), 32'(e_ovr));
                if (e_valid) begin
                    chk(sample_data === e_data, "R5 R7", "sample word", 32'(sample_data), 32'(e_data));
                    chk(marker_err === e_err, "R6", "marker flag", 32'(marker_err), 32'(e_err));
                end
                if (sample_valid === 1'b1) n_valid++;
                if (sample_valid === 1'b1 && marker_err === 1'b1) n_err++;
                if (overrun === 1'b1) n_ovr++;
            end
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go_idle();
        enable = 1'b0;
        while (adc_csn_n !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int v0, e0, o0;
        wait_cycles(5);
        rst = 1'b0;
        wait_cycles(20);                  // R2: enable low, no frames
        chk(n_valid == 0, "R2", "frames while disabled", 32'(n_valid), 0);

        enable = 1'b1;                    // fast clock, relaxed period
        wait_cycles(400);
        chk(n_valid > 0, "R7", "frames at fast clock", 32'(n_valid), 1);

        go_idle();                        // slower data clock
        frame_div = 32'd300; sclk_div = 16'd2; enable = 1'b1;
        wait_cycles(1500);

        go_idle();                        // R6: bad marker
        e0 = n_err; v0 = n_valid;
        inject_mark = 1; enable = 1'b1;
        wait_cycles(1000);
        go_idle();
        chk(n_err > e0, "R6", "marker errors flagged", 32'(n_err - e0), 1);
        chk(n_valid > v0, "R6", "data still delivered", 32'(n_valid - v0), 1);
        inject_mark = 0;

        o0 = n_ovr;                       // R8: period shorter than a frame
        frame_div = 32'd9; sclk_div = 16'd0; enable = 1'b1;
        wait_cycles(500);
        chk(n_ovr > o0, "R8", "overruns seen", 32'(n_ovr - o0), 1);

        go_idle();                        // wide clock, disable mid-frame
        frame_div = 32'd400; sclk_div = 16'd5; enable = 1'b1;
        wait_cycles(480);
        enable = 1'b0;
        wait_cycles(400);
        enable = 1'b1;
        wait_cycles(1500);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule